// File: doc/BRIEF.md
# Burst Write/Read Data Handshake for a Memory Controller User Port

This block sits on the user side of a DRAM controller. A user issues one command at a time: a write or a read, with a burst address. For a write, the block raises a one-cycle "ready for data" pulse and then takes a burst of eight consecutive data words. The first word arrives one or two clocks after that pulse, depending on a delay setting that is captured when the command is accepted. For a read, the block returns the eight stored words of the addressed burst in order on its read bus, with a valid strobe. The memory side is a small register-based burst store, so the handshake can be exercised on its own, without a real device.

While a burst is in progress the block drops its ready output and ignores any new command. Ready comes back in the cycle after the last beat, so a new command can follow with no idle cycle between.

Top module: `user_data_handshake`

## Requirements
- R1: During and right after reset, `ready` is 1, `dinRdy` is 0, `rdValid` is 0, `rdData` is 0, and every stored word reads as 0.
- R2: A command is accepted at a rising edge where `cmdValid` and `ready` are both 1. `cmdWrite`=1 selects a write and 0 selects a read. `ready` is 0 from the next cycle until the burst completes.
- R3: For an accepted write, `dinRdy` is 1 for exactly one cycle, the cycle right after acceptance, and at no other time.
- R4: Write data is sampled on eight consecutive cycles. The first sampled cycle is D cycles after the `dinRdy` cycle, where D=1 when `wrDelaySel`=0 and D=2 when `wrDelaySel`=1. Beat k is stored as word k of the addressed burst. Values on `wrData` outside those cycles are not stored.
- R5: The delay used for a write is the `wrDelaySel` value present at acceptance. Changes to `wrDelaySel` after acceptance do not affect that write.
- R6: For an accepted read, `rdValid` is 1 for exactly eight consecutive cycles, starting the cycle after acceptance. During those cycles `rdData` carries words 0 to 7 of the addressed burst, in order.
- R7: Whenever `rdValid` is 0, `rdData` is 0.
- R8: A `cmdValid` pulse while `ready` is 0 has no effect: no `dinRdy`, no stored word changes, and the burst in progress continues unchanged.
- R9: Bursts at different addresses are independent. Writing one burst does not change another.
- R10: `ready` returns to 1 in the cycle right after the final beat of a write or read, and a command can be accepted in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command request strobe |
| cmdWrite | input | 1 | 1 = write burst, 0 = read burst |
| cmdAddr | input | ADDR_W | Burst address |
| wrDelaySel | input | 1 | Write data lag after `dinRdy`: 0 = one clock, 1 = two clocks |
| wrData | input | DATA_W | Write data beat |
| ready | output | 1 | Idle; a command can be accepted |
| dinRdy | output | 1 | One-cycle pulse: write data may follow |
| rdData | output | DATA_W | Read data beat, 0 when not valid |
| rdValid | output | 1 | Read data valid |

## Verification
The assertions assume that commands are issued only on `ready`. A `cmdValid` seen while busy is treated as noise that must be dropped. They also assume that the user times write beats by counting from `dinRdy`, not by sampling anything else. The stimulus keeps to these assumptions for every write. It also deliberately holds `cmdValid` high during a read burst and toggles `wrDelaySel` after acceptance. It places junk data on `wrData` in the cycles around the beat window, so that mis-timed sampling shows up as corrupted read-back.

// File: rtl/uhs_pkg.sv
package uhs_pkg;
  localparam int BEAT_W    = 3;
  localparam int BURST_LEN = 1 << BEAT_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RDY,
    ST_GAP,
    ST_CAP,
    ST_RD
  } hsState_t;

  typedef struct packed {
    logic              latchCmd;
    logic              capEn;
    logic              rdEn;
    logic [BEAT_W-1:0] beat;
  } hsStrobe_t;
endpackage

// File: rtl/uhs_ctrl.sv
module uhs_ctrl
  import uhs_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cmdValid,
  input  logic      cmdWrite,
  input  logic      wrDelaySel,
  output logic      ready,
  output logic      dinRdy,
  output logic      rdValid,
  output hsStrobe_t strobe
);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_LEN - 1);

  hsState_t          stateQ;
  hsState_t          stateD;
  logic [BEAT_W-1:0] beatQ;
  logic              delayQ;
  logic              accept;

  assign accept = cmdValid && (stateQ == ST_IDLE);

  always_comb begin
    stateD = stateQ;
    case (stateQ)
      ST_IDLE: if (accept) stateD = cmdWrite ? ST_RDY : ST_RD;
      ST_RDY:  stateD = delayQ ? ST_GAP : ST_CAP;
      ST_GAP:  stateD = ST_CAP;
      ST_CAP:  if (beatQ == LAST_BEAT) stateD = ST_IDLE;
      ST_RD:   if (beatQ == LAST_BEAT) stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stateQ <= ST_IDLE;
      beatQ  <= '0;
      delayQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (accept) begin
        beatQ  <= '0;
        delayQ <= wrDelaySel;
      end else if (stateQ == ST_CAP || stateQ == ST_RD) begin
        beatQ <= beatQ + 1'b1;
      end
    end
  end

  assign ready          = (stateQ == ST_IDLE);
  assign dinRdy         = (stateQ == ST_RDY);
  assign rdValid        = (stateQ == ST_RD);
  assign strobe.latchCmd = accept;
  assign strobe.capEn    = (stateQ == ST_CAP);
  assign strobe.rdEn     = (stateQ == ST_RD);
  assign strobe.beat     = beatQ;

  AST_DINRDY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    dinRdy |=> !dinRdy); // R3
  AST_DINRDY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dinRdy) |-> $past(cmdValid && cmdWrite && ready)); // R3
  AST_RDVALID_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdValid) |-> $past(cmdValid && !cmdWrite && ready)); // R6
  AST_READY_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (rdValid && beatQ == LAST_BEAT) |=> ready); // R10
endmodule

// File: rtl/uhs_dpath.sv
module uhs_dpath
  import uhs_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  hsStrobe_t         strobe,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  localparam int DEPTH = (1 << ADDR_W) * BURST_LEN;
  localparam int IDX_W = ADDR_W + BEAT_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] addrQ;
  logic [IDX_W-1:0]  idx;

  assign idx = {addrQ, strobe.beat};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addrQ <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (strobe.latchCmd) addrQ <= cmdAddr;
      if (strobe.capEn) mem[idx] <= wrData;
    end
  end

  assign rdData = strobe.rdEn ? mem[idx] : '0;

  AST_CAP_RD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.capEn |-> !strobe.rdEn); // R6
  AST_LATCH_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.latchCmd |-> !(strobe.capEn || strobe.rdEn)); // R8
endmodule

// File: rtl/user_data_handshake.sv
module user_data_handshake
  import uhs_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmdValid,
  input  logic              cmdWrite,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic              wrDelaySel,
  input  logic [DATA_W-1:0] wrData,
  output logic              ready,
  output logic              dinRdy,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  hsStrobe_t strobe;

  uhs_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmdValid   (cmdValid),
    .cmdWrite   (cmdWrite),
    .wrDelaySel (wrDelaySel),
    .ready      (ready),
    .dinRdy     (dinRdy),
    .rdValid    (rdValid),
    .strobe     (strobe)
  );

  uhs_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dpath (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .cmdAddr (cmdAddr),
    .wrData  (wrData),
    .rdData  (rdData)
  );
endmodule

// File: tb/sim_user_data_handshake.sv
module sim_user_data_handshake;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmdValid = 1'b0;
  logic          cmdWrite = 1'b0;
  logic [AW-1:0] cmdAddr = '0;
  logic          wrDelaySel = 1'b0;
  logic [DW-1:0] wrData = '0;
  logic          ready, dinRdy, rdValid;
  logic [DW-1:0] rdData;

  int nChecks = 0;
  int nErrors = 0;
  logic [DW-1:0] model [8][8];
  logic [DW-1:0] expQ [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  user_data_handshake #(.DATA_W(DW), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdWrite(cmdWrite),
    .cmdAddr(cmdAddr), .wrDelaySel(wrDelaySel), .wrData(wrData),
    .ready(ready), .dinRdy(dinRdy), .rdData(rdData), .rdValid(rdValid)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor: pops expected read beats, checks quiet bus otherwise
  always @(negedge clk) begin
    if (rst_n) begin
      if (rdValid) begin
        chk("R2 ready low during read", {31'd0, ready}, 32'd0);
        if (expQ.size() == 0) begin
          chk("R6 unexpected rdValid", 32'd1, 32'd0);
        end else begin
          chk("R6 read beat", {16'd0, rdData}, {16'd0, expQ.pop_front()});
        end
      end else begin
        chk("R7 rdData idle zero", {16'd0, rdData}, 32'd0);
      end
    end
  end

  task automatic doWrite(int a, bit sel, logic [DW-1:0] base, bit flipSel);
    cmdValid = 1'b1; cmdWrite = 1'b1; cmdAddr = AW'(a);
    wrDelaySel = sel; wrData = 16'hBAD0;
    @(negedge clk);
    chk("R3 dinRdy after accept", {31'd0, dinRdy}, 32'd1);
    chk("R2 ready low after accept", {31'd0, ready}, 32'd0);
    cmdValid = 1'b0;
    if (flipSel) wrDelaySel = ~sel;  // R5
    wrData = 16'hBAD1;
    if (sel) begin
      @(negedge clk);
      chk("R3 dinRdy one cycle", {31'd0, dinRdy}, 32'd0);
      wrData = 16'hBAD2;
    end
    for (int b = 0; b < 8; b++) begin
      @(negedge clk);
      wrData = base + DW'(b);
      model[a][b] = base + DW'(b);
      chk("R3 dinRdy quiet in beats", {31'd0, dinRdy}, 32'd0);
    end
    @(negedge clk);
    wrData = 16'hBAD3;
    chk("R10 ready after write", {31'd0, ready}, 32'd1);
  endtask

  task automatic doRead(int a);
    cmdValid = 1'b1; cmdWrite = 1'b0; cmdAddr = AW'(a);
    for (int b = 0; b < 8; b++) expQ.push_back(model[a][b]);
    @(negedge clk);
    cmdValid = 1'b0;
    chk("R6 rdValid starts", {31'd0, rdValid}, 32'd1);
    repeat (7) @(negedge clk);
    chk("R6 rdValid last beat", {31'd0, rdValid}, 32'd1);
    @(negedge clk);
    chk("R6 rdValid ends", {31'd0, rdValid}, 32'd0);
    chk("R10 ready after read", {31'd0, ready}, 32'd1);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nErrors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++) model[i][j] = '0;
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", {31'd0, ready}, 32'd1);
    chk("R1 dinRdy in reset", {31'd0, dinRdy}, 32'd0);
    chk("R1 rdValid in reset", {31'd0, rdValid}, 32'd0);
    chk("R1 rdData in reset", {16'd0, rdData}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", {31'd0, ready}, 32'd1);

    doRead(7);                      // R1 R9 unwritten burst reads zero
    doWrite(1, 1'b0, 16'h1100, 1'b0); // R4 D=1
    doWrite(3, 1'b1, 16'h3300, 1'b0); // R4 D=2
    doRead(1);
    doRead(3);
    doRead(0);                      // R9 untouched neighbour
    doWrite(5, 1'b0, 16'h5500, 1'b1); // R5 flip after accept
    doWrite(6, 1'b1, 16'h6600, 1'b1); // R5 flip after accept
    doRead(5);
    doRead(6);

    // R8: command held during a read burst is dropped
    cmdValid = 1'b1; cmdWrite = 1'b0; cmdAddr = 3'd3;
    for (int b = 0; b < 8; b++) expQ.push_back(model[3][b]);
    @(negedge clk);
    cmdWrite = 1'b1; cmdAddr = 3'd3; wrData = 16'hEEEE;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk("R8 no dinRdy while busy", {31'd0, dinRdy}, 32'd0);
    end
    cmdValid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R8 R10 ready after busy read", {31'd0, ready}, 32'd1);
    doRead(3);                      // R8 content unchanged

    // R10 back-to-back write then read
    doWrite(1, 1'b1, 16'hA100, 1'b0);
    doRead(1);
    doRead(3);                      // R9 other burst intact

    repeat (3) @(negedge clk);
    chk("R6 scoreboard drained", expQ.size(), 32'd0);
    finish_run();
  end
endmodule